// File: doc/BRIEF.md
# Ternary Zero-Skip Gating Controller

This block sits directly behind a ternary weight decoder. Each cycle it looks at the 2-bit decoded weight code that arrives with a token-valid strobe. When a valid token carries the zero code, it raises a skip signal and forces the address it sends to the downstream lookup table to zero. The table access can then be operand-isolated, because its address stays put and its result is not needed.

Alongside the gating path the block keeps two saturating statistics counters. One counts valid tokens whose weight is zero, and the other counts all valid tokens. From these it derives a flag that says whether the measured zero ratio reaches one quarter. The flag is formed with a two-bit left shift and a magnitude compare, so the block contains no multiplier. A synchronous clear restarts a measurement window without a full reset.

Top module: `zero_skip_ctrl`

## Requirements
- R1: `skip` is high exactly when `token_valid` is high and `tern_code` equals 2'b00 (zero weight). Codes 2'b01 (+1), 2'b11 (-1) and the unused 2'b10 never raise `skip`, and `skip` is low whenever `token_valid` is low. This output is combinational from the current inputs.
- R2: `lut_index` is 0 while `skip` is high, and otherwise equals `raw_index`. This output is combinational.
- R3: On each rising clock edge with `token_valid` high and `rst` and `clr` low, `total_count` increases by one, whatever the code.
- R4: On each rising clock edge with `token_valid` high, `tern_code` equal to 2'b00, and `rst` and `clr` low, `zero_count` increases by one. A valid token with a non-zero code leaves `zero_count` unchanged.
- R5: On an edge with `token_valid` low and `clr` low, both counters keep their values.
- R6: Both counters saturate at all-ones (`CNT_W` bits, default 32) and never wrap.
- R7: `clr` high at an edge sets both counters to zero, and it takes priority over a token accepted in the same cycle.
- R8: `rst` high at an edge (synchronous, active-high) sets both counters to zero.
- R9: `ratio_ok` is high exactly when `total_count` is non-zero and `zero_count` shifted left by two bits is greater than or equal to `total_count`, that is, when the zero ratio is at least 1/4. It follows the counters combinationally and is formed without any multiply operator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of both statistics counters |
| token_valid | input | 1 | A token is present this cycle |
| tern_code | input | 2 | Decoded ternary weight: 00 zero, 01 plus one, 11 minus one, 10 unused |
| raw_index | input | IDX_W (8) | Lookup-table address before gating |
| skip | output | 1 | Zero weight on a valid token |
| lut_index | output | IDX_W (8) | Gated lookup-table address |
| zero_count | output | CNT_W (32) | Saturating count of valid zero-weight tokens |
| total_count | output | CNT_W (32) | Saturating count of valid tokens |
| ratio_ok | output | 1 | Zero ratio has reached at least one quarter |

## Verification
Saturation is the hardest case to reach from the ports. With 32-bit counters it would take about four billion valid tokens. The bench therefore drives a second instance, built with a 4-bit counter width, from the same stimulus. It pushes more than fifteen valid zero tokens through both instances, which pins both counters of the narrow instance at all-ones. It then continues with non-zero codes and idle cycles to show that the counters do not wrap. The exact one-quarter ratio boundary is reached by clearing the counters and then sending one zero token plus three non-zero tokens, then a fourth non-zero token to step just below the boundary.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int TERN_W = 2;

  typedef enum logic [TERN_W-1:0] {
    TERN_ZERO = 2'b00,
    TERN_POS  = 2'b01,
    TERN_RSV  = 2'b10,
    TERN_NEG  = 2'b11
  } tern_e;

  function automatic logic is_zero_weight(input logic [TERN_W-1:0] code);
    return code == TERN_ZERO;
  endfunction
endpackage

// File: rtl/zs_gate.sv
module zs_gate
  import zs_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              valid,
  input  logic [TERN_W-1:0] code,
  input  logic [IDX_W-1:0]  idx_in,
  output logic              skip,
  output logic [IDX_W-1:0]  idx_out
);
  always_comb begin
    skip    = valid & is_zero_weight(code);
    idx_out = skip ? '0 : idx_in;
  end
endmodule

// File: rtl/zs_sat_counter.sv
module zs_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && (count != MAXV)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/zs_ratio_flag.sv
module zs_ratio_flag #(
  parameter int W = 32
) (
  input  logic [W-1:0] zeros,
  input  logic [W-1:0] total,
  output logic         meets
);
  localparam int EW = W + 2;

  logic [EW-1:0] zeros_x4;
  logic [EW-1:0] total_ext;

  always_comb begin
    zeros_x4  = {zeros, 2'b00};
    total_ext = {2'b00, total};
    meets     = (total != '0) && (zeros_x4 >= total_ext);
  end
endmodule

// File: rtl/zero_skip_ctrl.sv
module zero_skip_ctrl
  import zs_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              token_valid,
  input  logic [TERN_W-1:0] tern_code,
  input  logic [IDX_W-1:0]  raw_index,
  output logic              skip,
  output logic [IDX_W-1:0]  lut_index,
  output logic [CNT_W-1:0]  zero_count,
  output logic [CNT_W-1:0]  total_count,
  output logic              ratio_ok
);
  logic skip_w;

  zs_gate #(.IDX_W(IDX_W)) u_gate (
    .valid   (token_valid),
    .code    (tern_code),
    .idx_in  (raw_index),
    .skip    (skip_w),
    .idx_out (lut_index)
  );

  assign skip = skip_w;

  zs_sat_counter #(.W(CNT_W)) u_zero_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .inc   (skip_w),
    .count (zero_count)
  );

  zs_sat_counter #(.W(CNT_W)) u_total_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .inc   (token_valid),
    .count (total_count)
  );

  zs_ratio_flag #(.W(CNT_W)) u_ratio (
    .zeros (zero_count),
    .total (total_count),
    .meets (ratio_ok)
  );
endmodule

// File: rtl/zero_skip_ctrl_chk.sv
module zero_skip_ctrl_chk #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             token_valid,
  input logic [1:0]       tern_code,
  input logic [IDX_W-1:0] raw_index,
  input logic             skip,
  input logic [IDX_W-1:0] lut_index,
  input logic [CNT_W-1:0] zero_count,
  input logic [CNT_W-1:0] total_count,
  input logic             ratio_ok
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R1: skip only on a valid zero code
  p_skip_code_r1: assert property (@(posedge clk) disable iff (rst)
    skip |-> (token_valid && tern_code == 2'b00));
  p_skip_needed_r1: assert property (@(posedge clk) disable iff (rst)
    (token_valid && tern_code == 2'b00) |-> skip);

  // R2: gated address is zero while skipping, raw otherwise
  p_index_gate_r2: assert property (@(posedge clk) disable iff (rst)
    skip ? (lut_index == '0) : (lut_index == raw_index));

  // R3: total steps by one per accepted token
  p_total_step_r3: assert property (@(posedge clk) disable iff (rst)
    (token_valid && !clr && total_count != CMAX) |=> total_count == $past(total_count) + 1'b1);

  // R4: zero counter steps on zero codes, holds on others
  p_zero_step_r4: assert property (@(posedge clk) disable iff (rst)
    (skip && !clr && zero_count != CMAX) |=> zero_count == $past(zero_count) + 1'b1);
  p_zero_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (token_valid && tern_code != 2'b00 && !clr) |=> $stable(zero_count));

  // R5: idle cycles hold both counters
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!token_valid && !clr) |=> ($stable(zero_count) && $stable(total_count)));

  // R6: saturated counters stay at all-ones
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (total_count == CMAX && !clr) |=> total_count == CMAX);
  p_zero_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (zero_count == CMAX && !clr) |=> zero_count == CMAX);

  // R7: clear wins over a same-cycle token
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (zero_count == '0 && total_count == '0));

  // R8: synchronous reset zeroes the counters
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (zero_count == '0 && total_count == '0));

  // R9: flag is low with no tokens, and high when zeros dominate
  p_ratio_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (total_count == '0) |-> !ratio_ok);
  p_ratio_full_r9: assert property (@(posedge clk) disable iff (rst)
    (total_count != '0 && zero_count >= total_count) |-> ratio_ok);
endmodule

bind zero_skip_ctrl zero_skip_ctrl_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr         (clr),
  .token_valid (token_valid),
  .tern_code   (tern_code),
  .raw_index   (raw_index),
  .skip        (skip),
  .lut_index   (lut_index),
  .zero_count  (zero_count),
  .total_count (total_count),
  .ratio_ok    (ratio_ok)
);

// File: tb/zero_skip_ctrl_tb.sv
`timescale 1ns/1ps
module zero_skip_ctrl_tb;
  localparam int IDX_W = 8;
  localparam int NW    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             clr = 1'b0;
  logic             token_valid = 1'b0;
  logic [1:0]       tern_code = 2'b00;
  logic [IDX_W-1:0] raw_index = '0;

  logic             skip, skip_n;
  logic [IDX_W-1:0] lut_index, lut_index_n;
  logic [31:0]      zero_count, total_count;
  logic [NW-1:0]    zero_n, total_n;
  logic             ratio_ok, ratio_n;

  always #2 clk = ~clk;  // 250 MHz

  zero_skip_ctrl u_dut (
    .clk(clk), .rst(rst), .clr(clr), .token_valid(token_valid),
    .tern_code(tern_code), .raw_index(raw_index), .skip(skip),
    .lut_index(lut_index), .zero_count(zero_count),
    .total_count(total_count), .ratio_ok(ratio_ok)
  );

  zero_skip_ctrl #(.IDX_W(IDX_W), .CNT_W(NW)) u_dut_narrow (
    .clk(clk), .rst(rst), .clr(clr), .token_valid(token_valid),
    .tern_code(tern_code), .raw_index(raw_index), .skip(skip_n),
    .lut_index(lut_index_n), .zero_count(zero_n),
    .total_count(total_n), .ratio_ok(ratio_n)
  );

  typedef struct {
    longint z_w; longint t_w; bit r_w;
    longint z_n; longint t_n; bit r_n;
    string  tag;
  } exp_t;

  exp_t   sb[$];
  int     n_checks = 0;
  int     n_fail   = 0;
  longint mz_w = 0, mt_w = 0, mz_n = 0, mt_n = 0;
  localparam longint MAX_W = 64'hFFFF_FFFF;
  localparam longint MAX_N = (64'd1 << NW) - 1;

  function automatic bit ratio_model(longint z, longint t);
    return (t != 0) && (z * 4 >= t);
  endfunction

  task automatic chk(string tag, string what, longint got, longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Driver: drives one cycle, checks combinational outputs, queues expected counters
  task automatic drive(input bit r, input bit c, input bit v,
                       input logic [1:0] code, input logic [IDX_W-1:0] idx,
                       input string tag);
    exp_t e;
    bit   exp_skip;
    @(negedge clk);
    rst = r; clr = c; token_valid = v; tern_code = code; raw_index = idx;
    #1;
    exp_skip = v && (code == 2'b00);
    chk("R1", "skip", skip, exp_skip);
    chk("R1", "skip narrow", skip_n, exp_skip);
    chk("R2", "lut_index", lut_index, exp_skip ? 0 : idx);
    if (r || c) begin
      mz_w = 0; mt_w = 0; mz_n = 0; mt_n = 0;
    end else if (v) begin
      if (mt_w < MAX_W) mt_w++;
      if (mt_n < MAX_N) mt_n++;
      if (code == 2'b00) begin
        if (mz_w < MAX_W) mz_w++;
        if (mz_n < MAX_N) mz_n++;
      end
    end
    e.z_w = mz_w; e.t_w = mt_w; e.r_w = ratio_model(mz_w, mt_w);
    e.z_n = mz_n; e.t_n = mt_n; e.r_n = ratio_model(mz_n, mt_n);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: after each edge compare counters and flag against the queue head
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "zero_count (R4)", zero_count, e.z_w);
        chk(e.tag, "total_count (R3)", total_count, e.t_w);
        chk(e.tag, "ratio_ok (R9)", ratio_ok, e.r_w);
        chk(e.tag, "narrow zero_count (R6)", zero_n, e.z_n);
        chk(e.tag, "narrow total_count (R6)", total_n, e.t_n);
        chk(e.tag, "narrow ratio_ok (R9)", ratio_n, e.r_n);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    // R8: reset state
    drive(1, 0, 1, 2'b00, 8'h11, "R8");
    drive(1, 0, 1, 2'b01, 8'h22, "R8");
    // R5: idle cycles, including a zero code without valid
    drive(0, 0, 0, 2'b00, 8'h33, "R5");
    drive(0, 0, 0, 2'b11, 8'h44, "R5");
    // R1/R3/R4: each code once
    drive(0, 0, 1, 2'b00, 8'hA5, "R4");
    drive(0, 0, 1, 2'b01, 8'h5A, "R3");
    drive(0, 0, 1, 2'b10, 8'hC3, "R3");
    drive(0, 0, 1, 2'b11, 8'h3C, "R3");
    drive(0, 0, 0, 2'b00, 8'hFF, "R5");
    // R7: clear together with a valid zero token
    drive(0, 1, 1, 2'b00, 8'h01, "R7");
    // R9: exact one quarter, then just below
    drive(0, 0, 1, 2'b00, 8'h10, "R9");
    drive(0, 0, 1, 2'b01, 8'h11, "R9");
    drive(0, 0, 1, 2'b11, 8'h12, "R9");
    drive(0, 0, 1, 2'b10, 8'h13, "R9");
    drive(0, 0, 1, 2'b01, 8'h14, "R9");
    drive(0, 0, 0, 2'b01, 8'h15, "R9");
    // R6: saturate the narrow instance
    drive(0, 1, 0, 2'b00, 8'h00, "R7");
    for (int i = 0; i < 20; i++) drive(0, 0, 1, 2'b00, 8'(i + 1), "R6");
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 2'b01, 8'(i + 7), "R6");
    drive(0, 0, 0, 2'b00, 8'h66, "R6");
    // R8: reset mid-run
    drive(1, 0, 1, 2'b00, 8'h77, "R8");
    // Mixed pattern from a pseudo-random sequence
    lfsr = 8'hB1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(0, (i % 97) == 96, lfsr[0] | lfsr[6], lfsr[2:1], lfsr ^ 8'h5C, "R3");
    end
    drive(0, 0, 0, 2'b00, 8'h00, "R5");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule